// File: doc/BRIEF.md
# Zero-Address Stack Arithmetic Unit

This block holds the operands of zero-address instructions in a small internal word array, selected by its own pointer register. Each clock cycle it accepts one command: idle, push (with a data word), pop (which returns a word), or add. Add combines the two topmost entries and leaves their sum on the stack, so arithmetic needs no operand address at all. Entries come back in last-in, first-out order.

The pointer always counts the live entries. A push stores its word in the slot the pointer names and then advances the pointer. A pop first steps the pointer back and then reads the slot it now names. Commands that would take an entry from an empty stack, or push onto a full one, are refused: an error flag is raised and the stack stays as it was. Returned words are registered and are marked valid in the cycle after the pop. The parameter `SAT_ADD` selects how an add that overflows the word width is handled.

Top module: `zstack_alu`

## Requirements
- R1: Successful pops return the pushed words in last-in, first-out order, including words written by add.
- R2: While `rst_n` is low and after its release, `ptr_o` is 0 (empty stack) and `pop_valid_o`, `ovf_o`, `udf_o` are low and `pop_data_o` is 0.
- R3: A push (`cmd_i` = 1) on a stack that is not full stores `push_data_i` in slot `ptr_o` and `ptr_o` reads one higher after the clock edge.
- R4: A pop (`cmd_i` = 2) on a non-empty stack makes `ptr_o` one lower after the edge and returns the word in slot at the new pointer on `pop_data_o`, with `pop_valid_o` high for exactly the one cycle after the pop command.
- R5: An add (`cmd_i` = 3) with at least two entries writes the sum of the two topmost entries into the slot below the top, and `ptr_o` reads one lower, so the sum becomes the new top.
- R6: A pop on an empty stack, or an add with fewer than two entries, raises `udf_o` for one cycle after the command and leaves `ptr_o`, the contents and `pop_valid_o` (low) unchanged.
- R7: A push when `ptr_o` equals `DEPTH` raises `ovf_o` for one cycle after the command, keeps `ptr_o`, and overwrites no stored entry.
- R8: With `SAT_ADD` = 0 the sum keeps the low `DATA_W` bits (wraps); with `SAT_ADD` = 1 an unsigned carry out clamps the sum to all ones.
- R9: Idle (`cmd_i` = 0) changes neither `ptr_o` nor the contents, and raises no flag.
- R10: `pop_data_o` holds the last returned word until the next successful pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command: 0 idle, 1 push, 2 pop, 3 add |
| push_data_i | input | DATA_W | Word stored by a push |
| pop_data_o | output | DATA_W | Registered word returned by the last pop |
| pop_valid_o | output | 1 | High for one cycle when `pop_data_o` carries a fresh word |
| ptr_o | output | $clog2(DEPTH+1) | Stack pointer, equal to the number of live entries |
| ovf_o | output | 1 | One-cycle pulse after a refused push |
| udf_o | output | 1 | One-cycle pulse after a refused pop or add |

## Verification
The bench builds two copies with an 8-bit word and a depth of four, one wrapping and one saturating, driven by the same commands. The shallow depth lets the stack be filled and overrun within a few commands, so the full and empty boundaries and refused commands are reached often. The narrow word makes an add carry out with small operands, so wrap and clamp are compared on the same sum.

// File: rtl/zsa_pkg.sv
package zsa_pkg;

   typedef enum logic [1:0] {
      ZSA_IDLE = 2'd0,
      ZSA_PUSH = 2'd1,
      ZSA_POP  = 2'd2,
      ZSA_ADD  = 2'd3
   } zsa_cmd_e;

endpackage

// File: rtl/zsa_ptr_ctrl.sv
module zsa_ptr_ctrl #(
   parameter int DEPTH = 8,
   parameter int PTR_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cmd_i,
   output logic [PTR_W-1:0] ptr_o,
   output logic [PTR_W-1:0] top_addr_o,
   output logic [PTR_W-1:0] below_addr_o,
   output logic             push_ok_o,
   output logic             pop_ok_o,
   output logic             add_ok_o,
   output logic             ovf_hit_o,
   output logic             udf_hit_o
);
   import zsa_pkg::*;

   localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);
   localparam logic [PTR_W-1:0] ONE      = PTR_W'(1);
   localparam logic [PTR_W-1:0] TWO      = PTR_W'(2);

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_d;
   zsa_cmd_e         cmd;
   logic             is_empty;
   logic             is_full;
   logic             has_pair;

   always_comb begin
      cmd      = zsa_cmd_e'(cmd_i);
      is_empty = (ptr_q == '0);
      is_full  = (ptr_q == FULL_LVL);
      has_pair = (ptr_q >= TWO);

      push_ok_o = (cmd == ZSA_PUSH) && !is_full;
      pop_ok_o  = (cmd == ZSA_POP)  && !is_empty;
      add_ok_o  = (cmd == ZSA_ADD)  && has_pair;
      ovf_hit_o = (cmd == ZSA_PUSH) && is_full;
      udf_hit_o = ((cmd == ZSA_POP) && is_empty) ||
                  ((cmd == ZSA_ADD) && !has_pair);

      top_addr_o   = ptr_q - ONE;
      below_addr_o = ptr_q - TWO;
   end

   always_comb begin
      ptr_d = ptr_q;
      if (push_ok_o) begin
         ptr_d = ptr_q + ONE;
      end else if (pop_ok_o || add_ok_o) begin
         ptr_d = ptr_q - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else begin
         ptr_q <= ptr_d;
      end
   end

   assign ptr_o = ptr_q;

endmodule

// File: rtl/zsa_store.sv
module zsa_store #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   parameter int PTR_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [PTR_W-1:0]  waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [PTR_W-1:0]  raddr_a_i,
   output logic [DATA_W-1:0] rdata_a_o,
   input  logic [PTR_W-1:0]  raddr_b_i,
   output logic [DATA_W-1:0] rdata_b_o
);
   localparam int FLAT_W = DEPTH * DATA_W;

   logic [FLAT_W-1:0] flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (we_i && (waddr_i == PTR_W'(g))) begin
            word_q <= wdata_i;
         end
      end
      assign flat[g*DATA_W +: DATA_W] = word_q;
   end

   always_comb begin
      rdata_a_o = '0;
      rdata_b_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (raddr_a_i == PTR_W'(i)) rdata_a_o = flat[i*DATA_W +: DATA_W];
         if (raddr_b_i == PTR_W'(i)) rdata_b_o = flat[i*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/zsa_adder.sv
module zsa_adder #(
   parameter int DATA_W  = 16,
   parameter int SAT_ADD = 0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] sum_o
);
   if (SAT_ADD == 0) begin : g_wrap
      assign sum_o = a_i + b_i;
   end else begin : g_clamp
      logic [DATA_W:0] wide;
      assign wide  = {1'b0, a_i} + {1'b0, b_i};
      assign sum_o = wide[DATA_W] ? {DATA_W{1'b1}} : wide[DATA_W-1:0];
   end

endmodule

// File: rtl/zstack_alu.sv
module zstack_alu #(
   parameter int DATA_W  = 16,
   parameter int DEPTH   = 8,
   parameter int SAT_ADD = 0,
   localparam int PTR_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd_i,
   input  logic [DATA_W-1:0] push_data_i,
   output logic [DATA_W-1:0] pop_data_o,
   output logic              pop_valid_o,
   output logic [PTR_W-1:0]  ptr_o,
   output logic              ovf_o,
   output logic              udf_o
);

   if (DATA_W < 1) begin : g_bad_width
      $error("zstack_alu: DATA_W must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("zstack_alu: DEPTH must be at least 2 so add has two operands");
   end
   if ((SAT_ADD != 0) && (SAT_ADD != 1)) begin : g_bad_mode
      $error("zstack_alu: SAT_ADD must be 0 or 1");
   end

   logic [PTR_W-1:0]  ptr;
   logic [PTR_W-1:0]  top_addr;
   logic [PTR_W-1:0]  below_addr;
   logic              push_ok;
   logic              pop_ok;
   logic              add_ok;
   logic              ovf_hit;
   logic              udf_hit;
   logic [DATA_W-1:0] top_word;
   logic [DATA_W-1:0] below_word;
   logic [DATA_W-1:0] sum;
   logic              wr_en;
   logic [PTR_W-1:0]  wr_addr;
   logic [DATA_W-1:0] wr_data;

   zsa_ptr_ctrl #(
      .DEPTH (DEPTH),
      .PTR_W (PTR_W)
   ) u_ptr (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_i        (cmd_i),
      .ptr_o        (ptr),
      .top_addr_o   (top_addr),
      .below_addr_o (below_addr),
      .push_ok_o    (push_ok),
      .pop_ok_o     (pop_ok),
      .add_ok_o     (add_ok),
      .ovf_hit_o    (ovf_hit),
      .udf_hit_o    (udf_hit)
   );

   always_comb begin
      wr_en   = push_ok || add_ok;
      wr_addr = push_ok ? ptr : below_addr;
      wr_data = push_ok ? push_data_i : sum;
   end

   zsa_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .PTR_W  (PTR_W)
   ) u_store (
      .clk       (clk),
      .we_i      (wr_en),
      .waddr_i   (wr_addr),
      .wdata_i   (wr_data),
      .raddr_a_i (top_addr),
      .rdata_a_o (top_word),
      .raddr_b_i (below_addr),
      .rdata_b_o (below_word)
   );

   zsa_adder #(
      .DATA_W  (DATA_W),
      .SAT_ADD (SAT_ADD)
   ) u_add (
      .a_i   (below_word),
      .b_i   (top_word),
      .sum_o (sum)
   );

   logic [DATA_W-1:0] pop_data_q;
   logic              pop_valid_q;
   logic              ovf_q;
   logic              udf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_data_q  <= '0;
         pop_valid_q <= 1'b0;
         ovf_q       <= 1'b0;
         udf_q       <= 1'b0;
      end else begin
         if (pop_ok) begin
            pop_data_q <= top_word;
         end
         pop_valid_q <= pop_ok;
         ovf_q       <= ovf_hit;
         udf_q       <= udf_hit;
      end
   end

   assign pop_data_o  = pop_data_q;
   assign pop_valid_o = pop_valid_q;
   assign ptr_o       = ptr;
   assign ovf_o       = ovf_q;
   assign udf_o       = udf_q;

endmodule

// File: rtl/zstack_alu_chk.sv
module zstack_alu_chk #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   parameter int PTR_W  = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cmd_i,
   input logic [DATA_W-1:0] pop_data_o,
   input logic              pop_valid_o,
   input logic [PTR_W-1:0]  ptr_o,
   input logic              ovf_o,
   input logic              udf_o
);
   localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH);
   localparam logic [PTR_W-1:0] ONE      = PTR_W'(1);
   localparam logic [PTR_W-1:0] TWO      = PTR_W'(2);

   // R2: the pointer never leaves the range 0..DEPTH
   p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_o <= FULL_LVL);

   p_push_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 2'd1 && ptr_o != FULL_LVL) |=> (ptr_o == $past(ptr_o) + ONE) && !ovf_o);

   p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 2'd2 && ptr_o != '0) |=> (ptr_o == $past(ptr_o) - ONE) && pop_valid_o);

   p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_i == 2'd2 && ptr_o != '0) |=> !pop_valid_o);

   p_add_shrink_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 2'd3 && ptr_o >= TWO) |=> (ptr_o == $past(ptr_o) - ONE) && !udf_o);

   p_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_i == 2'd2 && ptr_o == '0) || (cmd_i == 2'd3 && ptr_o < TWO))
      |=> udf_o && $stable(ptr_o) && !pop_valid_o);

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 2'd1 && ptr_o == FULL_LVL) |=> ovf_o && $stable(ptr_o));

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 2'd0) |=> $stable(ptr_o) && !ovf_o && !udf_o);

   p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_i == 2'd2 && ptr_o != '0) |=> $stable(pop_data_o));

endmodule

bind zstack_alu zstack_alu_chk #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH),
   .PTR_W  (PTR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_i       (cmd_i),
   .pop_data_o  (pop_data_o),
   .pop_valid_o (pop_valid_o),
   .ptr_o       (ptr_o),
   .ovf_o       (ovf_o),
   .udf_o       (udf_o)
);

// File: tb/zstack_alu_bench.sv
module zstack_alu_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW  = 8;
   localparam int DEP = 4;
   localparam int PW  = $clog2(DEP + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cmd_i = 2'd0;
   logic [DW-1:0] push_data_i = '0;

   logic [DW-1:0] pop_data_o, pop_data_s;
   logic          pop_valid_o, pop_valid_s;
   logic [PW-1:0] ptr_o, ptr_s;
   logic          ovf_o, ovf_s, udf_o, udf_s;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   logic [DW-1:0] mdl   [DEP];
   logic [DW-1:0] mdl_s [DEP];
   int            cnt = 0;
   logic [DW-1:0] last_pop = '0;
   logic [DW-1:0] exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   zstack_alu #(.DATA_W(DW), .DEPTH(DEP), .SAT_ADD(0)) u_zstack_alu (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .push_data_i(push_data_i),
      .pop_data_o(pop_data_o), .pop_valid_o(pop_valid_o), .ptr_o(ptr_o),
      .ovf_o(ovf_o), .udf_o(udf_o));

   zstack_alu #(.DATA_W(DW), .DEPTH(DEP), .SAT_ADD(1)) u_zstack_alu_sat (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .push_data_i(push_data_i),
      .pop_data_o(pop_data_s), .pop_valid_o(pop_valid_s), .ptr_o(ptr_s),
      .ovf_o(ovf_s), .udf_o(udf_s));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   // monitor: compares each returned word against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && pop_valid_o) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "valid without a pending pop", 1, 0);
         end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            chk(pop_data_o == e, "R1", "pop order", pop_data_o, e);
         end
      end
   end

   // driver: updates the reference stack, issues the command, checks state
   task automatic run(input logic [1:0] c, input logic [DW-1:0] d, input string tag);
      bit            e_ovf = 0, e_udf = 0, e_val = 0;
      logic [DW-1:0] e_sat = '0;
      case (c)
         2'd1: if (cnt == DEP) e_ovf = 1;
               else begin mdl[cnt] = d; mdl_s[cnt] = d; cnt++; end
         2'd2: if (cnt == 0) e_udf = 1;
               else begin
                  cnt--;
                  exp_q.push_back(mdl[cnt]);
                  e_val = 1; e_sat = mdl_s[cnt]; last_pop = mdl[cnt];
               end
         2'd3: if (cnt < 2) e_udf = 1;
               else begin
                  int s;
                  mdl[cnt-2] = DW'(mdl[cnt-2] + mdl[cnt-1]);
                  s = int'(mdl_s[cnt-2]) + int'(mdl_s[cnt-1]);
                  mdl_s[cnt-2] = (s > 255) ? 8'hFF : DW'(s);
                  cnt--;
               end
         default: ;
      endcase
      cmd_i = c;
      push_data_i = d;
      @(posedge clk);
      @(negedge clk);
      cmd_i = 2'd0;
      chk(ptr_o == PW'(cnt), tag, "pointer", ptr_o, cnt);
      chk(ovf_o == e_ovf, tag, "overflow flag (R7)", ovf_o, e_ovf);
      chk(udf_o == e_udf, tag, "underflow flag (R6)", udf_o, e_udf);
      chk(pop_valid_o == e_val, tag, "valid pulse (R4)", pop_valid_o, e_val);
      if (e_val) chk(pop_data_s == e_sat, "R8", "saturating copy word", pop_data_s, e_sat);
      else       chk(pop_data_o == last_pop, "R10", "held word", pop_data_o, last_pop);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", "run did not finish", 0, 1);
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(ptr_o == '0, "R2", "pointer in reset", ptr_o, 0);
      chk(!pop_valid_o && !ovf_o && !udf_o, "R2", "flags in reset",
          {pop_valid_o, ovf_o, udf_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ptr_o == '0 && pop_data_o == '0, "R2", "state after release", ptr_o, 0);

      run(2'd2, 8'd0, "R6");          // pop on empty
      run(2'd3, 8'd0, "R6");          // add on empty
      run(2'd1, 8'd10, "R3");
      run(2'd3, 8'd0, "R6");          // add with one entry
      run(2'd0, 8'd55, "R9");
      run(2'd2, 8'd0, "R4");          // returns 10

      run(2'd1, 8'd1, "R3");
      run(2'd1, 8'd2, "R3");
      run(2'd1, 8'd3, "R3");
      run(2'd1, 8'd4, "R3");
      run(2'd1, 8'd99, "R7");         // refused, 4 stays on top
      run(2'd0, 8'd0, "R9");
      for (int k = 0; k < 4; k++) run(2'd2, 8'd0, "R1");
      run(2'd0, 8'd0, "R10");
      run(2'd2, 8'd0, "R6");

      run(2'd1, 8'd7, "R3");
      run(2'd1, 8'd9, "R3");
      run(2'd3, 8'd0, "R5");
      run(2'd2, 8'd0, "R5");          // 16

      run(2'd1, 8'd200, "R8");
      run(2'd1, 8'd100, "R8");
      run(2'd3, 8'd0, "R8");
      run(2'd2, 8'd0, "R8");          // 44 wrapped, 255 clamped

      run(2'd1, 8'd1, "R5");
      run(2'd1, 8'd2, "R5");
      run(2'd1, 8'd3, "R5");
      run(2'd3, 8'd0, "R5");
      run(2'd3, 8'd0, "R5");
      run(2'd1, 8'd4, "R3");          // lands above the sum
      run(2'd2, 8'd0, "R1");
      run(2'd2, 8'd0, "R5");          // 6
      run(2'd2, 8'd0, "R6");

      @(negedge clk);
      chk(exp_q.size() == 0, "R4", "all expected words returned", exp_q.size(), 0);
      done = 1'b1;
      report();
   end

endmodule